// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters over a three-wire synchronous link: a serial clock that it drives as master, a data output and a data input. Transmit and receive run full duplex on the same serial clock. Each direction has two stages. On the transmit side a holding register feeds a shift register. On the receive side a shift register feeds a holding register. Software can therefore queue the next character, or collect the previous one, while a character is still on the wire.

A character goes out whenever the transmit holding register is occupied. The sequencer divides the system clock by a programmable half-period to produce equal low and high serial-clock phases. Data leaves on falling edges and is captured on rising edges, least significant bit first. Between characters the serial clock and the data line rest high. If another character is waiting when the eighth bit ends, the clock keeps running with no gap. Every character slot also shifts in one character from the data input, and that character is posted to the receive holding register together with full and overrun status.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, sclk_o and sdo_o are 1, tx_empty_o is 1, rx_full_o is 0 and rx_ovr_o is 0.
- R2: Each character is 8 bits, sent least significant bit first. sdo_o changes only in the system cycle in which sclk_o goes from 1 to 0, or when the link returns to idle after the last bit.
- R3: While a character is in flight, each low phase and each high phase of sclk_o lasts exactly max(half_div_i, 1) system clock cycles. half_div_i is captured when a character starts.
- R4: The receiver takes sdi_i as it stands at the system clock edge that drives sclk_o from 0 to 1. The first such sample is bit 0 of the character.
- R5: With no character in flight, sclk_o and sdo_o stay at 1. Once the transmit holding register is occupied and the link is idle, sclk_o falls on the next system clock edge, with sdo_o carrying bit 0.
- R6: A write (tx_wr_i) while tx_empty_o is 1 stores tx_data_i and clears tx_empty_o on the next edge. tx_empty_o returns to 1 when the character moves into the shift register. A write while tx_empty_o is 0 is ignored.
- R7: If the holding register is occupied when the high phase of the 8th bit ends, the next character's first falling edge comes at that point, so its preceding high phase is exactly one half-period long.
- R8: At the 8th rising-edge sample the received character is placed on rx_data_o and rx_full_o is set. A one-cycle rx_rd_i clears rx_full_o and rx_ovr_o.
- R9: If a character completes while rx_full_o is 1 and rx_rd_i is 0, rx_ovr_o is set, the new character is dropped and rx_data_o keeps the older one.
- R10: The received character depends only on sdi_i and is independent of the character being transmitted in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_div_i | input | DIV_W | System cycles per serial-clock phase (0 treated as 1) |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | DATA_W | Character to transmit |
| tx_empty_o | output | 1 | Transmit holding register can accept a character |
| rx_rd_i | input | 1 | Acknowledge of the received character |
| rx_data_o | output | DATA_W | Last received character |
| rx_full_o | output | 1 | Received character waiting |
| rx_ovr_o | output | 1 | A character was lost because the previous one was not read |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The bound checker checks these on every cycle: the idle-high state of both serial outputs, data changing only at falling edges or at the return to idle, the exact length of every low phase and every in-character high phase (which also covers the back-to-back case), the transmit-empty handshake, and the receive-full, read-clear and overrun updates. Some behaviour depends on values, and only the bench's scenarios can show it: that the bits come out in least-significant-first order, that the receiver gets exactly the bits driven during the low phases, and that the two directions do not mix. The same holds for a write being ignored while the buffer is full and for the gap-free second character, which need a particular sequence of stimulus.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

  // per-cycle strobes issued by the sequencer
  typedef struct packed {
    logic load;    // holding register -> shift register, sclk falls next
    logic shift;   // advance to next transmit bit, sclk falls next
    logic sample;  // capture sdi, sclk rises next
    logic last;    // sample of the final bit of a character
  } ssx_evt_t;

  function automatic logic [31:0] ssx_bit_w(input int n);
    return (n > 1) ? 32'($clog2(n)) : 32'd1;
  endfunction

endpackage

// File: rtl/ssx_seq.sv
module ssx_seq
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_pend_i,
  input  logic [DIV_W-1:0] half_div_i,
  output ssx_evt_t         evt_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic [DIV_W-1:0] hdiv_o
);
  localparam int BIT_W = int'(ssx_bit_w(DATA_W));
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

  logic             busy_q, sclk_q;
  logic [DIV_W-1:0] cnt_q, hdiv_q, hdiv_eff;
  logic [BIT_W-1:0] bit_q;
  logic             tick, at_last, load, sample, shift, stop;

  always_comb begin
    hdiv_eff = (half_div_i == '0) ? DIV_ONE : half_div_i;
    tick     = busy_q && (cnt_q == hdiv_q - DIV_ONE);
    at_last  = (bit_q == LAST_BIT);
    load     = tx_pend_i && (!busy_q || (tick && sclk_q && at_last));
    sample   = tick && !sclk_q;
    shift    = tick && sclk_q && !at_last;
    stop     = tick && sclk_q && at_last && !tx_pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      bit_q  <= '0;
      hdiv_q <= DIV_ONE;
    end else if (load) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      hdiv_q <= hdiv_eff;
    end else if (sample) begin
      sclk_q <= 1'b1;
      cnt_q  <= '0;
    end else if (shift) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= bit_q + 1'b1;
    end else if (stop) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + DIV_ONE;
    end
  end

  always_comb begin
    evt_o.load   = load;
    evt_o.shift  = shift;
    evt_o.sample = sample;
    evt_o.last   = sample && at_last;
  end

  assign busy_o = busy_q;
  assign sclk_o = sclk_q;
  assign hdiv_o = hdiv_q;

endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              busy_i,
  output logic              full_o,
  output logic              sdo_o
);
  logic [DATA_W-1:0] hold_q, sh_q;
  logic              full_q;

  // load only when full, write only when empty: never in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (load_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      hold_q <= data_i;
      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= hold_q;
    end else if (shift_i) begin
      sh_q <= {1'b1, sh_q[DATA_W-1:1]};
    end
  end

  assign full_o = full_q;
  assign sdo_o  = busy_i ? sh_q[0] : 1'b1;

endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              sdi_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] sh_q, sh_nxt, data_q;
  logic              full_q, ovr_q;

  assign sh_nxt = {sdi_i, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (sample_i) sh_q <= sh_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_i) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (last_i) begin
        if (full_q && !rd_i) begin
          ovr_q <= 1'b1;  // newest character dropped
        end else begin
          data_q <= sh_nxt;
          full_q <= 1'b1;
        end
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_empty_o,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              rx_ovr_o,
  output logic              sclk_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  ssx_evt_t         seq_evt;
  logic             seq_busy;
  logic [DIV_W-1:0] seq_hdiv;
  logic             tx_full;
  logic             rx_done;

  ssx_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_pend_i  (tx_full),
    .half_div_i (half_div_i),
    .evt_o      (seq_evt),
    .busy_o     (seq_busy),
    .sclk_o     (sclk_o),
    .hdiv_o     (seq_hdiv)
  );

  ssx_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (tx_wr_i),
    .data_i  (tx_data_i),
    .load_i  (seq_evt.load),
    .shift_i (seq_evt.shift),
    .busy_i  (seq_busy),
    .full_o  (tx_full),
    .sdo_o   (sdo_o)
  );

  ssx_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (seq_evt.sample),
    .last_i   (seq_evt.last),
    .sdi_i    (sdi_i),
    .rd_i     (rx_rd_i),
    .data_o   (rx_data_o),
    .full_o   (rx_full_o),
    .ovr_o    (rx_ovr_o)
  );

  assign tx_empty_o = !tx_full;
  assign rx_done    = seq_evt.last;

endmodule

// File: rtl/ssx_chk.sv
module ssx_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              sdo_i,
  input logic              tx_wr_i,
  input logic              tx_empty_i,
  input logic              rx_rd_i,
  input logic              rx_full_i,
  input logic              rx_ovr_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              busy_i,
  input logic [DIV_W-1:0]  hdiv_i,
  input logic              last_i
);
  logic             prev_s, prev_d, prev_b;
  logic [DIV_W:0]   run_q;
  logic [DIV_W-1:0] hd_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_s  <= 1'b1;
      prev_d  <= 1'b1;
      prev_b  <= 1'b0;
      run_q   <= '0;
      hd_rise <= '0;
    end else begin
      prev_s <= sclk_i;
      prev_d <= sdo_i;
      prev_b <= busy_i;
      if (sclk_i != prev_s) run_q <= (DIV_W+1)'(1);
      else if (run_q != '1) run_q <= run_q + 1'b1;
      if (sclk_i && !prev_s) hd_rise <= hdiv_i;
    end
  end

  a_r5_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sclk_i && sdo_i));

  a_r2_sdo_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_i != prev_d) |-> ((!sclk_i && prev_s) || (!busy_i && prev_b)));

  a_r3_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_i && !prev_s) |-> (run_q == {1'b0, hdiv_i}));

  // also covers R7: a back-to-back start keeps the last high phase exact
  a_r3_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_i && prev_s && prev_b) |-> (run_q == {1'b0, hd_rise}));

  a_r3_div_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (hdiv_i != '0));

  a_r6_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_empty_i) |=> !tx_empty_i);

  a_r8_done_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> rx_full_i);

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !last_i) |=> (!rx_full_i && !rx_ovr_i));

  a_r9_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_i && rx_full_i && !rx_rd_i) |=> (rx_ovr_i && $stable(rx_data_i)));

endmodule

bind sync_serial_xcvr ssx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sclk_i     (sclk_o),
  .sdo_i      (sdo_o),
  .tx_wr_i    (tx_wr_i),
  .tx_empty_i (tx_empty_o),
  .rx_rd_i    (rx_rd_i),
  .rx_full_i  (rx_full_o),
  .rx_ovr_i   (rx_ovr_o),
  .rx_data_i  (rx_data_o),
  .busy_i     (seq_busy),
  .hdiv_i     (seq_hdiv),
  .last_i     (rx_done)
);

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int DW = 8;
  localparam int VW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [VW-1:0] half_div_i = VW'(2);
  logic          tx_wr_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic          tx_empty_o;
  logic          rx_rd_i = 1'b0;
  logic [DW-1:0] rx_data_o;
  logic          rx_full_o, rx_ovr_o, sclk_o, sdo_o;
  logic          sdi_i = 1'b1;

  always #10 clk_i = ~clk_i;

  sync_serial_xcvr #(.DATA_W(DW), .DIV_W(VW)) u_sync_serial_xcvr (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_div_i(half_div_i),
    .tx_wr_i(tx_wr_i), .tx_data_i(tx_data_i), .tx_empty_o(tx_empty_o),
    .rx_rd_i(rx_rd_i), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
    .rx_ovr_o(rx_ovr_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rx_pat(input int n);
    return 8'((n * 73 + 44) ^ 90);
  endfunction

  function automatic int eff_div(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  // line monitor / far-end model
  int         cur_div = 2, run = 0, bit_n = 8, rx_fno = 0, b2b_seen = 0, tx_frames = 0;
  bit         in_frame = 1'b0;
  logic       prev_s = 1'b1, prev_d = 1'b1;
  logic [7:0] sh = '0, pat = '0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_exp[$];

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (sdo_o !== prev_d && !(prev_s && !sclk_o) && bit_n != 8)
        chk(1'b0, "R2 sdo changed off a falling edge", int'(sdo_o), int'(prev_d));
      if (sclk_o !== prev_s) begin
        if (sclk_o) begin
          chk(run == cur_div, "R3 low phase length", run, cur_div);
          sh[bit_n] = sdo_o;
          bit_n++;
          if (bit_n == 8) begin
            tx_frames++;
            if (tx_q.size() > 0) begin
              chk(sh == tx_q[0], "R2 character LSB first", int'(sh), int'(tx_q[0]));
              void'(tx_q.pop_front());
            end else begin
              chk(1'b0, "R6 unexpected character sent", int'(sh), 0);
            end
            rx_exp.push_back(rx_pat(rx_fno));
            rx_fno++;
          end
        end else begin
          if (in_frame && bit_n < 8)
            chk(run == cur_div, "R3 high phase length", run, cur_div);
          if (!in_frame || bit_n == 8) begin
            if (in_frame && run == cur_div) b2b_seen++;
            in_frame = 1'b1;
            bit_n = 0;
          end
          pat = rx_pat(rx_fno);
          sdi_i <= pat[bit_n];
        end
        run = 1;
      end else begin
        run++;
        if (in_frame && bit_n == 8 && run > cur_div) in_frame = 1'b0;
      end
      prev_s = sclk_o;
      prev_d = sdo_o;
    end
  end

  task automatic wr_tx(input logic [7:0] b, input bit accepted);
    tx_data_i = b;
    tx_wr_i = 1'b1;
    if (accepted) tx_q.push_back(b);
    @(negedge clk_i);
    tx_wr_i = 1'b0;
  endtask

  task automatic rd_rx();
    rx_rd_i = 1'b1;
    @(negedge clk_i);
    rx_rd_i = 1'b0;
  endtask

  task automatic wait_rx();
    int n = 0;
    while (!rx_full_o && n < 5000) begin @(negedge clk_i); n++; end
    @(negedge clk_i);
  endtask

  task automatic wait_frames(input int target);
    int n = 0;
    while (tx_frames < target && n < 5000) begin @(negedge clk_i); n++; end
    repeat (4 * cur_div + 4) @(negedge clk_i);
  endtask

  task automatic rx_compare(input string req);
    if (rx_exp.size() > 0) begin
      chk(rx_data_o == rx_exp[0], req, int'(rx_data_o), int'(rx_exp[0]));
      void'(rx_exp.pop_front());
    end else begin
      chk(1'b0, {req, " no expected character"}, int'(rx_data_o), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic [7:0] b;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    // R1: state under reset and right after release
    chk(sclk_o == 1'b1, "R1 sclk reset", int'(sclk_o), 1);
    chk(sdo_o == 1'b1, "R1 sdo reset", int'(sdo_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(tx_empty_o == 1'b1, "R1 tx_empty reset", int'(tx_empty_o), 1);
    chk(rx_full_o == 1'b0, "R1 rx_full reset", int'(rx_full_o), 0);
    chk(rx_ovr_o == 1'b0, "R1 rx_ovr reset", int'(rx_ovr_o), 0);
    repeat (5) @(negedge clk_i);
    chk(sclk_o == 1'b1 && sdo_o == 1'b1, "R5 idle lines high", int'({sclk_o, sdo_o}), 3);

    // R5/R6: start of a single character
    wr_tx(8'h5A, 1'b1);
    chk(tx_empty_o == 1'b0, "R6 write clears empty", int'(tx_empty_o), 0);
    chk(sclk_o == 1'b1, "R5 clock still high before load", int'(sclk_o), 1);
    @(negedge clk_i);
    chk(tx_empty_o == 1'b1, "R6 empty set on load", int'(tx_empty_o), 1);
    chk(sclk_o == 1'b0, "R5 clock falls on load", int'(sclk_o), 0);
    chk(sdo_o == 1'b0, "R2 bit0 on first fall", int'(sdo_o), 0);
    wait_rx();
    chk(rx_full_o == 1'b1, "R8 rx_full after character", int'(rx_full_o), 1);
    rx_compare("R4 received character");
    rd_rx();
    chk(rx_full_o == 1'b0, "R8 read clears full", int'(rx_full_o), 0);
    wait_frames(1);

    // R6/R7/R9: streamed pair, ignored third write, overrun
    base = b2b_seen;
    wr_tx(8'h3C, 1'b1);
    while (!tx_empty_o) @(negedge clk_i);
    wr_tx(8'hC3, 1'b1);
    wr_tx(8'hFF, 1'b0);
    chk(tx_empty_o == 1'b0, "R6 still full after ignored write", int'(tx_empty_o), 0);
    wait_frames(3);
    repeat (40) @(negedge clk_i);
    chk(tx_frames == 3, "R6 ignored write not sent", tx_frames, 3);
    chk(b2b_seen == base + 1, "R7 back-to-back without gap", b2b_seen, base + 1);
    chk(rx_full_o == 1'b1, "R9 full held", int'(rx_full_o), 1);
    chk(rx_ovr_o == 1'b1, "R9 overrun set", int'(rx_ovr_o), 1);
    rx_compare("R9 older character kept");
    rx_exp.delete();
    rd_rx();
    chk(rx_full_o == 1'b0 && rx_ovr_o == 1'b0, "R8 read clears full and overrun",
        int'({rx_full_o, rx_ovr_o}), 0);

    // R3: divisor 0 acts as 1
    half_div_i = '0;
    cur_div = eff_div(0);
    wr_tx(8'h81, 1'b1);
    wait_rx();
    rx_compare("R3 character at minimum divisor");
    rd_rx();

    // random traffic, varying divisor between characters
    for (int i = 0; i < 30; i++) begin
      half_div_i = VW'($urandom_range(1, 5));
      cur_div = eff_div(int'(half_div_i));
      b = 8'($urandom);
      wr_tx(b, 1'b1);
      wait_rx();
      rx_compare("R10 full-duplex receive");
      rd_rx();
    end
    wait_frames(tx_frames);
    chk(tx_q.size() == 0, "R2 all characters sent", tx_q.size(), 0);
    chk(sclk_o == 1'b1 && sdo_o == 1'b1, "R5 lines back to idle", int'({sclk_o, sdo_o}), 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule